// File: doc/BRIEF.md
# Chainable Limb Left Shifter

The block shifts a big integer left by 0 to W-1 bits while the integer streams through it one W-bit limb per beat, least significant limb first. For each limb it rotates the source left by the shift amount, then uses a mask to split the rotated value. The upper positions go to the output limb, and the positions below them are filled from a carry-in. The wrapped-around low bits become a carry-out. A carry register passes each carry-out to the next limb as its carry-in, so a stream of any length leaves the block shifted as one number. Only a W-bit rotator and a mask are needed, and no copy of the source vector is kept.

A beat flagged as start takes its carry-in from a shift-in operand. This lets the caller inject bits below the number, and zero gives a plain shift. Beats that are not flagged as start take the carry register instead. On the beat flagged last, the final carry-out (the bits pushed beyond the top limb) is presented on a separate overflow output, alongside the last output limb. The output stage is a single register. It accepts a new beat whenever it is empty or being drained.

Top module: `limb_shl`

## Requirements
- R1: After reset, `out_valid` and `ovf_valid` are 0 and `in_ready` is 1.
- R2: The shift amount n is the low log2(W) bits of `in_amt` (0 to 63 for W=64). All higher bits of `in_amt` have no effect.
- R3: For an accepted beat, output bit positions n..W-1 carry the source limb shifted left by n. Positions 0..n-1 carry bits 0..n-1 of the carry-in.
- R4: The carry-out of a beat is the top n source bits, placed in positions 0..n-1 with zeros above them. It is the carry-in of the next beat that lacks `in_start`, so a stream of limbs V yields the limbs of (V << n) | shift-in bits.
- R5: A beat with `in_start`=1 takes its carry-in from the low n bits of `in_shin`. On beats with `in_start`=0, `in_shin` has no effect.
- R6: With n=0 the output limb equals the source limb and the carry-out is zero.
- R7: The output beat that comes from an input beat with `in_last`=1 has `out_last`=1 and `ovf_valid`=1. `ovf_limb` then holds that beat's carry-out. `ovf_valid` is 0 on every other output beat and while no output is valid.
- R8: An accepted input appears on the output one cycle later. `in_ready` is 1 exactly when the output register is empty or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, the output holds its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_start | input | 1 | First limb of a number; load carry from in_shin |
| in_last | input | 1 | Final limb of a number |
| in_limb | input | W | Source limb |
| in_amt | input | W | Shift amount operand (low log2(W) bits used) |
| in_shin | input | W | Bits shifted in below the first limb |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_limb | output | W | Shifted, merged limb |
| out_last | output | 1 | Output beat is the final limb |
| ovf_valid | output | 1 | Overflow limb present (with the last limb) |
| ovf_limb | output | W | Bits pushed past the top of the number |

## Verification
The properties assume that the source drives `in_valid` and the beat fields stably, and that the sink drives `out_ready`, without reacting to the same clock edge. They also assume that `in_amt` stays meaningful only through its low bits. The stimulus changes inputs just after a rising edge and reads outputs at the falling edge. Each stream opens with a start beat and closes with a last beat. Upper `in_amt` bits and `in_shin` on non-start beats are filled with noise, so that the parts of the inputs that must be ignored are exercised.

// File: rtl/limb_shl.sv
module limb_shl #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_start,
  input  logic         in_last,
  input  logic [W-1:0] in_limb,
  input  logic [W-1:0] in_amt,
  input  logic [W-1:0] in_shin,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_limb,
  output logic         out_last,
  output logic         ovf_valid,
  output logic [W-1:0] ovf_limb
);
  localparam int AW = $clog2(W);

  logic [AW-1:0]  n;
  logic [2*W-1:0] dbl;
  logic [W-1:0]   rot, mask, cin, merged, cout, carry_q;
  logic           take;

  assign n      = in_amt[AW-1:0];
  assign dbl    = {in_limb, in_limb} << n;
  assign rot    = dbl[2*W-1:W];
  assign mask   = {W{1'b1}} << n;
  assign cin    = in_start ? in_shin : carry_q;
  assign merged = (rot & mask) | (cin & ~mask);
  assign cout   = rot & ~mask;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ovf_valid <= 1'b0;
      out_last  <= 1'b0;
      out_limb  <= '0;
      ovf_limb  <= '0;
      carry_q   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      ovf_valid <= in_valid && in_last;
      if (in_valid) begin
        out_limb <= merged;
        out_last <= in_last;
        carry_q  <= cout;
        if (in_last) ovf_limb <= cout;
      end
    end
  end
endmodule

// File: rtl/limb_shl_chk.sv
module limb_shl_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic [W-1:0] in_limb,
  input logic [W-1:0] in_amt,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_limb,
  input logic         out_last,
  input logic         ovf_valid,
  input logic [W-1:0] ovf_limb
);
  localparam int AW = $clog2(W);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_limb) && $stable(out_last) && $stable(ovf_limb));

  p_zero_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_amt[AW-1:0] == '0 |=> out_limb == $past(in_limb));

  p_zero_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last && in_amt[AW-1:0] == '0 |=> ovf_limb == '0);

  p_ovf_with_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> out_valid && out_last);

  p_last_has_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> ovf_valid);
endmodule

bind limb_shl limb_shl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .in_limb(in_limb), .in_amt(in_amt),
  .out_valid(out_valid), .out_ready(out_ready), .out_limb(out_limb),
  .out_last(out_last), .ovf_valid(ovf_valid), .ovf_limb(ovf_limb)
);

// File: tb/limb_shl_bench.sv
module limb_shl_bench;
  localparam int W  = 64;
  localparam int ML = 4;
  localparam int BW = (ML + 1) * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_limb = '0, in_amt = '0, in_shin = '0;
  logic in_ready, out_valid, out_last, ovf_valid;
  logic [W-1:0] out_limb, ovf_limb;

  always #2 clk = ~clk;

  limb_shl #(.W(W)) u_limb_shl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_last(in_last), .in_limb(in_limb),
    .in_amt(in_amt), .in_shin(in_shin), .out_valid(out_valid),
    .out_ready(out_ready), .out_limb(out_limb), .out_last(out_last),
    .ovf_valid(ovf_valid), .ovf_limb(ovf_limb)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] exp_limb [0:2047];
  logic         exp_last [0:2047];
  logic [W-1:0] exp_ovf  [0:2047];
  int wr = 0, rd = 0;
  logic [63:0] lfsr = 64'h9e3779b97f4a7c15;
  bit stall_mode = 0;

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] nxt(logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      chk(out_limb == exp_limb[rd], "R3/R4 limb", out_limb, exp_limb[rd]);
      chk(out_last == exp_last[rd], "R7 last", {63'd0, out_last}, {63'd0, exp_last[rd]});
      chk(ovf_valid == exp_last[rd], "R7 ovf_valid", {63'd0, ovf_valid}, {63'd0, exp_last[rd]});
      if (exp_last[rd]) chk(ovf_limb == exp_ovf[rd], "R7 ovf_limb", ovf_limb, exp_ovf[rd]);
      rd++;
    end else if (rst_n && !out_valid) begin
      chk(!ovf_valid, "R7 idle ovf", {63'd0, ovf_valid}, '0);
    end
  end

  logic [W-1:0] held;
  bit held_ok = 0;
  always @(negedge clk) begin
    if (held_ok) chk(out_valid && out_limb == held, "R8 hold", out_limb, held);
    held_ok = rst_n && out_valid && !out_ready;
    held = out_limb;
  end

  task automatic send(int nl, int n, logic [W-1:0] shin, logic [BW-1:0] v);
    logic [BW-1:0] r;
    logic [BW-1:0] lowm;
    lowm = (BW'(1) << n) - BW'(1);
    r = (v << n) | ({{(BW-W){1'b0}}, shin} & lowm);
    for (int i = 0; i < nl; i++) begin
      exp_limb[wr] = r[i*W +: W];
      exp_last[wr] = (i == nl - 1);
      exp_ovf[wr]  = r[nl*W +: W];
      wr++;
    end
    for (int i = 0; i < nl; i++) begin
      bit acc;
      lfsr = nxt(lfsr);
      in_valid = 1'b1;
      in_start = (i == 0);
      in_last  = (i == nl - 1);
      in_limb  = v[i*W +: W];
      in_amt   = {lfsr[63:6], 6'(n)};
      in_shin  = (i == 0) ? shin : lfsr;
      do begin
        @(negedge clk);
        acc = in_ready;
        @(posedge clk);
        #1;
        if (stall_mode) begin
          lfsr = nxt(lfsr);
          out_ready = lfsr[3] | lfsr[7];
        end
      end while (!acc);
    end
    in_valid = 1'b0;
    in_start = 1'b0;
    in_last = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !ovf_valid && in_ready, "R1 reset",
        {61'd0, out_valid, ovf_valid, in_ready}, 64'd1);
    // R8 latency: single beat, output after one edge
    in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1;
    in_limb = 64'h8000_0000_0000_0001; in_amt = 64'hffff_ffff_ffff_ff04; in_shin = 64'hf;
    exp_limb[wr] = 64'h0000_0000_0000_001f; exp_last[wr] = 1; exp_ovf[wr] = 64'h8; wr++;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid, "R8 latency", {63'd0, out_valid}, 64'd1);
    @(posedge clk); #1;
    // R2 R5 R6 sweep over all shift amounts and patterns
    for (int p = 0; p < 3; p++) begin
      stall_mode = (p == 2);
      for (int n = 0; n < W; n++) begin
        int nl = 1 + (n % ML);
        v = '0;
        for (int i = 0; i < nl; i++) begin
          lfsr = nxt(lfsr);
          case (p)
            0: v[i*W +: W] = '1;
            1: v[i*W +: W] = 64'h8000_0000_0000_0001 << (i + n % 5);
            default: v[i*W +: W] = lfsr;
          endcase
        end
        lfsr = nxt(lfsr);
        send(nl, n, (p == 1) ? '0 : lfsr, v);
      end
    end
    stall_mode = 0;
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(rd == wr, "R4 beat count", 64'(rd), 64'(wr));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule